// File: doc/BRIEF.md
# Dual-Read X/Y Data Memory

This block is a byte-addressed data memory of 16-bit words whose implemented range is cut into two regions at a boundary fixed at build time. Bytes below the boundary form the X region. Bytes from the boundary up to the end of implemented memory form the Y region. Two reads can complete in the same cycle. The X read port sees the whole memory as one linear space, so it serves every ordinary load and also supplies the first operand of a dual-operand multiply-accumulate step. The Y read port reaches only the Y region and supplies the second operand of such a step. When a Y address falls outside its region, the port returns zero and flags an error for one cycle.

The single write port always sees the memory as one combined space. It writes either a whole word or one byte lane. Read data is registered, so both read ports have one cycle of latency. Every port carries a valid qualifier and there is no ready signal. The memory accepts a request on every cycle and never applies back-pressure. A result appears, marked by its data-valid output, exactly one cycle after the request is accepted. The consumer must take that result in that cycle, because it is replaced by the result of the next accepted request.

Top module: `xy_dual_read_mem`

## Requirements
- R1: While reset is asserted (rst_n low), x_rd_data_valid, y_rd_data_valid and y_rd_err are 0, and x_rd_data and y_rd_data are 0.
- R2: x_rd_data_valid is 1 in the cycle after x_rd_valid was sampled high, and 0 in the cycle after it was sampled low.
- R3: An X read returns the 16-bit word at word index addr>>1. Bit 0 of the address is ignored. An address at or above MEM_BYTES (default 2048) returns 0.
- R4: A Y read of an address in [Y_BASE, MEM_BYTES) (default [1024, 2048)) returns the word at addr>>1, one cycle after the request. y_rd_data_valid follows y_rd_valid with one cycle of delay, and a Y read completes in the same cycle as a concurrent X read.
- R5: A Y read whose address is below Y_BASE or at or above MEM_BYTES returns 0 and raises y_rd_err, together with y_rd_data_valid, for that single result cycle.
- R6: A write with wr_byte=0 replaces the whole word at wr_addr>>1, in either region.
- R7: A write with wr_byte=1 writes wr_data[7:0] into one byte of the word at wr_addr>>1: bits 7:0 when wr_addr[0]=0, bits 15:8 when wr_addr[0]=1. The other byte keeps its value.
- R8: A write to an address at or above MEM_BYTES changes no stored word.
- R9: A read of the word being written in the same cycle returns the old contents. A read in a later cycle returns the new contents.
- R10: A read port's data output holds its last value in every cycle after one in which that port had no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_rd_valid | input | 1 | X read request |
| x_rd_addr | input | 16 | X read byte address, unified space |
| x_rd_data_valid | output | 1 | X read result valid |
| x_rd_data | output | 16 | X read word |
| y_rd_valid | input | 1 | Y read request |
| y_rd_addr | input | 16 | Y read byte address |
| y_rd_data_valid | output | 1 | Y read result valid |
| y_rd_data | output | 16 | Y read word, or 0 on error |
| y_rd_err | output | 1 | Y address was outside the Y region |
| wr_valid | input | 1 | Write request |
| wr_addr | input | 16 | Write byte address, unified space |
| wr_byte | input | 1 | 1 selects a byte write, 0 a word write |
| wr_data | input | 16 | Write data; bits 7:0 only for byte writes |

## Verification
The assertions check these rules on every cycle:
- the one-cycle relation between each request and its data-valid output;
- the Y error flag, which must come from an out-of-region request and must carry zero data;
- zero data for X reads beyond the implemented memory;
- data that holds while a port is idle.

Only the bench scenarios can show that the correct word comes back. This covers:
- old data on a read that collides with a write;
- byte-lane merging;
- writes past the end of memory that leave stored words untouched;
- reads at the exact Y_BASE and MEM_BYTES boundaries.

The bench tracks all of this with a reference model of the memory contents.

// File: rtl/xy_mem_pkg.sv
package xy_mem_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    RG_X   = 2'd0,
    RG_Y   = 2'd1,
    RG_OUT = 2'd2
  } xy_region_e;
endpackage

// File: rtl/xy_region_decode.sv
module xy_region_decode
  import xy_mem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LANE_W    = 1,
  parameter int unsigned MEM_BYTES = 2048,
  parameter int unsigned Y_BASE    = 1024,
  localparam int unsigned WIDX_W   = $clog2(MEM_BYTES >> LANE_W)
) (
  input  logic [ADDR_W-1:0] addr,
  output xy_region_e        region,
  output logic [WIDX_W-1:0] word_idx
);
  localparam logic [ADDR_W:0] MEM_END = (ADDR_W+1)'(MEM_BYTES);
  localparam logic [ADDR_W:0] Y_START = (ADDR_W+1)'(Y_BASE);

  logic [ADDR_W:0] a_ext;

  always_comb begin
    a_ext    = {1'b0, addr};
    word_idx = addr[LANE_W +: WIDX_W];
    if (a_ext >= MEM_END)      region = RG_OUT;
    else if (a_ext >= Y_START) region = RG_Y;
    else                       region = RG_X;
  end
endmodule

// File: rtl/xy_word_store.sv
module xy_word_store
  import xy_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WORDS  = 1024,
  parameter int unsigned NPORTS = 2,
  localparam int unsigned NB     = DATA_W / BYTE_W,
  localparam int unsigned WIDX_W = $clog2(WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [WIDX_W-1:0]             wr_idx,
  input  logic [NB-1:0]                 wr_lane_en,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [NPORTS-1:0]             rd_en,
  input  logic [NPORTS-1:0]             rd_hit,
  input  logic [NPORTS-1:0][WIDX_W-1:0] rd_idx,
  output logic [NPORTS-1:0][DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] mem [WORDS];

  // Byte-lane write; reads below use nonblocking semantics, so a
  // same-cycle read of the written word samples the old contents.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < int'(NB); l++) begin
        if (wr_lane_en[l]) mem[wr_idx][l*BYTE_W +: BYTE_W] <= wr_data[l*BYTE_W +: BYTE_W];
      end
    end
  end

  for (genvar p = 0; p < int'(NPORTS); p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n)         rd_q[p] <= '0;
      else if (rd_en[p])  rd_q[p] <= rd_hit[p] ? mem[rd_idx[p]] : '0;
    end

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[p] |=> $stable(rd_q[p]));
  end
endmodule

// File: rtl/xy_dual_read_mem.sv
module xy_dual_read_mem
  import xy_mem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MEM_BYTES = 2048,
  parameter int unsigned Y_BASE    = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_rd_valid,
  input  logic [ADDR_W-1:0] x_rd_addr,
  output logic              x_rd_data_valid,
  output logic [DATA_W-1:0] x_rd_data,
  input  logic              y_rd_valid,
  input  logic [ADDR_W-1:0] y_rd_addr,
  output logic              y_rd_data_valid,
  output logic [DATA_W-1:0] y_rd_data,
  output logic              y_rd_err,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_byte,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned NB     = DATA_W / BYTE_W;
  localparam int unsigned LANE_W = $clog2(NB);
  localparam int unsigned WORDS  = MEM_BYTES / NB;
  localparam int unsigned WIDX_W = $clog2(WORDS);
  localparam logic [ADDR_W:0] MEM_END = (ADDR_W+1)'(MEM_BYTES);
  localparam logic [ADDR_W:0] Y_START = (ADDR_W+1)'(Y_BASE);

  xy_region_e        x_rg, y_rg, w_rg;
  logic [WIDX_W-1:0] x_idx, y_idx, w_idx;

  xy_region_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .MEM_BYTES(MEM_BYTES), .Y_BASE(Y_BASE))
    u_dec_x (.addr(x_rd_addr), .region(x_rg), .word_idx(x_idx));
  xy_region_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .MEM_BYTES(MEM_BYTES), .Y_BASE(Y_BASE))
    u_dec_y (.addr(y_rd_addr), .region(y_rg), .word_idx(y_idx));
  xy_region_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .MEM_BYTES(MEM_BYTES), .Y_BASE(Y_BASE))
    u_dec_w (.addr(wr_addr), .region(w_rg), .word_idx(w_idx));

  // Write: unified view, word or single byte lane.
  logic              w_en;
  logic [NB-1:0]     w_lanes;
  logic [DATA_W-1:0] w_data;

  always_comb begin
    w_en = wr_valid && (w_rg != RG_OUT);
    if (wr_byte) begin
      w_lanes = '0;
      w_lanes[wr_addr[LANE_W-1:0]] = 1'b1;
      w_data  = {NB{wr_data[BYTE_W-1:0]}};
    end else begin
      w_lanes = '1;
      w_data  = wr_data;
    end
  end

  // Read ports: port 0 unified X path, port 1 Y-only path.
  logic [1:0]             rd_en, rd_hit;
  logic [1:0][WIDX_W-1:0] rd_idx;
  logic [1:0][DATA_W-1:0] rd_q;

  always_comb begin
    rd_en  = {y_rd_valid, x_rd_valid};
    rd_hit = {(y_rg == RG_Y), (x_rg != RG_OUT)};
    rd_idx = {y_idx, x_idx};
  end

  xy_word_store #(.DATA_W(DATA_W), .WORDS(WORDS), .NPORTS(2)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(w_en), .wr_idx(w_idx), .wr_lane_en(w_lanes), .wr_data(w_data),
    .rd_en(rd_en), .rd_hit(rd_hit), .rd_idx(rd_idx), .rd_q(rd_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_rd_data_valid <= 1'b0;
      y_rd_data_valid <= 1'b0;
      y_rd_err        <= 1'b0;
    end else begin
      x_rd_data_valid <= x_rd_valid;
      y_rd_data_valid <= y_rd_valid;
      y_rd_err        <= y_rd_valid && (y_rg != RG_Y);
    end
  end

  assign x_rd_data = rd_q[0];
  assign y_rd_data = rd_q[1];

  a_r2_x_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    x_rd_valid |=> x_rd_data_valid);
  a_r2_x_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !x_rd_valid |=> !x_rd_data_valid);
  a_r4_y_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    y_rd_valid |=> y_rd_data_valid);
  a_r3_x_beyond_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (x_rd_valid && ({1'b0, x_rd_addr} >= MEM_END)) |=> (x_rd_data == '0));
  a_r5_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    y_rd_err |-> (y_rd_data_valid && (y_rd_data == '0)));
  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    y_rd_err |-> ($past(y_rd_valid) &&
      (({1'b0, $past(y_rd_addr)} < Y_START) || ({1'b0, $past(y_rd_addr)} >= MEM_END))));
  a_r5_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (y_rd_valid && ({1'b0, y_rd_addr} < Y_START)) |=> y_rd_err);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (!x_rd_data_valid && !y_rd_data_valid && !y_rd_err));
endmodule

// File: tb/xy_dual_read_mem_test.sv
module xy_dual_read_mem_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 2048;
  localparam int Y_BASE     = 1024;
  localparam int WORDS      = MEM_BYTES / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x_rd_valid = 1'b0, y_rd_valid = 1'b0, wr_valid = 1'b0, wr_byte = 1'b0;
  logic [15:0] x_rd_addr = '0, y_rd_addr = '0, wr_addr = '0, wr_data = '0;
  logic        x_rd_data_valid, y_rd_data_valid, y_rd_err;
  logic [15:0] x_rd_data, y_rd_data;

  int checks = 0;
  int bad    = 0;
  bit done   = 1'b0;

  logic [15:0] model [WORDS];
  logic [15:0] exp_xq = '0, exp_yq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xy_dual_read_mem #(.MEM_BYTES(MEM_BYTES), .Y_BASE(Y_BASE)) uut (
    .clk(clk), .rst_n(rst_n),
    .x_rd_valid(x_rd_valid), .x_rd_addr(x_rd_addr),
    .x_rd_data_valid(x_rd_data_valid), .x_rd_data(x_rd_data),
    .y_rd_valid(y_rd_valid), .y_rd_addr(y_rd_addr),
    .y_rd_data_valid(y_rd_data_valid), .y_rd_data(y_rd_data), .y_rd_err(y_rd_err),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_byte(wr_byte), .wr_data(wr_data)
  );

  function automatic logic [15:0] exp_x(input logic [15:0] a);
    return (int'(a) < MEM_BYTES) ? model[a[10:1]] : 16'h0;
  endfunction

  function automatic bit y_in(input logic [15:0] a);
    return (int'(a) >= Y_BASE) && (int'(a) < MEM_BYTES);
  endfunction

  function automatic logic [15:0] exp_y(input logic [15:0] a);
    return y_in(a) ? model[a[10:1]] : 16'h0;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compute expectations from the model,
  // update the model with the write, check after the next posedge.
  task automatic cycle(input bit xv, input logic [15:0] xa, input bit yv, input logic [15:0] ya,
                       input bit wv, input logic [15:0] wa, input bit wb, input logic [15:0] wd,
                       input string tag);
    string tx, ty;
    bit    e_err;
    x_rd_valid = xv; x_rd_addr = xa;
    y_rd_valid = yv; y_rd_addr = ya;
    wr_valid = wv; wr_addr = wa; wr_byte = wb; wr_data = wd;
    if (xv) exp_xq = exp_x(xa);
    if (yv) exp_yq = exp_y(ya);
    e_err = yv && !y_in(ya);
    tx = (tag != "") ? tag : (!xv ? "R10" : (int'(xa) >= MEM_BYTES ? "R3" : "R3"));
    ty = (tag != "") ? tag : (!yv ? "R10" : (e_err ? "R5" : "R4"));
    if (wv && wv && int'(wa) < MEM_BYTES) begin
      if (!wb)        model[wa[10:1]] = wd;
      else if (wa[0]) model[wa[10:1]][15:8] = wd[7:0];
      else            model[wa[10:1]][7:0]  = wd[7:0];
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2 x valid", {15'h0, x_rd_data_valid}, {15'h0, xv});
    chk({tx, " x data"}, x_rd_data, exp_xq);
    chk("R4 y valid", {15'h0, y_rd_data_valid}, {15'h0, yv});
    chk({ty, " y data"}, y_rd_data, exp_yq);
    chk("R5 y err", {15'h0, y_rd_err}, {15'h0, e_err});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1 x valid", {15'h0, x_rd_data_valid}, 16'h0);
    chk("R1 y valid", {15'h0, y_rd_data_valid}, 16'h0);
    chk("R1 y err",   {15'h0, y_rd_err}, 16'h0);
    chk("R1 x data",  x_rd_data, 16'h0);
    chk("R1 y data",  y_rd_data, 16'h0);
    rst_n = 1'b1;

    // R6: fill every word through the unified write port
    for (int i = 0; i < WORDS; i++)
      cycle(0, 0, 0, 0, 1, 16'(i*2), 0, 16'(i*16'h9E37 ^ 16'h5A5A), "R6");

    // R3: X reads, bit 0 ignored, beyond memory is zero
    cycle(1, 16'h0010, 0, 0, 0, 0, 0, 0, "R3");
    cycle(1, 16'h0011, 0, 0, 0, 0, 0, 0, "R3");
    cycle(1, 16'h0900, 0, 0, 0, 0, 0, 0, "R3");
    cycle(1, 16'h0402, 0, 0, 0, 0, 0, 0, "R3");
    // R4: concurrent X and Y, Y boundaries
    cycle(1, 16'h0002, 1, 16'h0402, 0, 0, 0, 0, "R4");
    cycle(1, 16'h0004, 1, 16'(Y_BASE), 0, 0, 0, 0, "R4");
    cycle(0, 0, 1, 16'(MEM_BYTES-1), 0, 0, 0, 0, "R4");
    // R5: Y out of region
    cycle(0, 0, 1, 16'h0010, 0, 0, 0, 0, "R5");
    cycle(0, 0, 1, 16'(Y_BASE-1), 0, 0, 0, 0, "R5");
    cycle(0, 0, 1, 16'(MEM_BYTES), 0, 0, 0, 0, "R5");
    cycle(0, 0, 1, 16'hFFFF, 0, 0, 0, 0, "R5");
    // R7: byte lanes
    cycle(0, 0, 0, 0, 1, 16'h0021, 1, 16'h77AB, "R7");
    cycle(1, 16'h0020, 0, 0, 1, 16'h0420, 1, 16'h88CD, "R7");
    cycle(0, 0, 1, 16'h0420, 0, 0, 0, 0, "R7");
    // R6: word write in Y region, read back on Y
    cycle(0, 0, 0, 0, 1, 16'h0500, 0, 16'hBEEF, "R6");
    cycle(1, 16'h0500, 1, 16'h0500, 0, 0, 0, 0, "R6");
    // R8: write beyond memory must not alias
    cycle(0, 0, 0, 0, 1, 16'(MEM_BYTES + 16'h0020), 0, 16'hDEAD, "R8");
    cycle(0, 0, 0, 0, 1, 16'hF000, 1, 16'h0011, "R8");
    cycle(1, 16'h0020, 1, 16'h0420, 0, 0, 0, 0, "R8");
    // R9: read-during-write returns old, then new
    cycle(1, 16'h0030, 0, 0, 1, 16'h0030, 0, 16'h1234, "R9");
    cycle(1, 16'h0030, 1, 16'h0430, 1, 16'h0430, 0, 16'h4321, "R9");
    cycle(1, 16'h0430, 1, 16'h0430, 0, 0, 0, 0, "R9");
    // R10: idle ports hold
    cycle(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    cycle(0, 16'h0002, 0, 16'h0002, 1, 16'h0430, 0, 16'h0F0F, "R10");

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] xa, ya, wa;
      xa = ($urandom_range(0, 9) == 0) ? 16'($urandom) : 16'($urandom_range(0, MEM_BYTES-1));
      ya = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, MEM_BYTES+255))
                                       : 16'($urandom_range(Y_BASE, MEM_BYTES-1));
      wa = ($urandom_range(0, 2) == 0) ? xa : 16'($urandom_range(0, MEM_BYTES+255));
      cycle(1'($urandom), xa, 1'($urandom), ya, 1'($urandom), wa, 1'($urandom),
            16'($urandom), "");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule